// File: doc/BRIEF.md
# Nonvolatile Shadow-RAM Transfer Controller

This block is the control logic in front of a memory that pairs a fast volatile array with a nonvolatile copy. It observes an SRAM-style bus (active-low chip enable, write enable and output enable, plus a 15-bit address) that has already been sampled into the clock domain. Each clock in which chip enable is low counts as one bus cycle: a read when write enable is high, a write when it is low. The block passes read and write strobes through to the array and tracks whether the volatile array has changed since the last transfer.

Whole-array transfers are started in four ways. Software starts one with six consecutive reads to a fixed address sequence. Any agent on the board starts a save by pulling the shared busy pin low. A power-fail event starts a save that first checks the pin. A power-restore event always starts a reload. The block issues a one-cycle start command for each transfer to the array model. It holds its busy output high for a fixed number of cycles and blocks all normal accesses for that time.

Top module: `nvram_ctrl`

## Requirements
- R1: After synchronous reset, busy, hsb_drive, xfer_store and xfer_recall are low and the array is marked clean, so a save request is skipped.
- R2: Six consecutive read cycles with addr[13:0] equal to 0x2A55, 0x15AA, 0x0F0F, 0x30F0, 0x0333 in that order, then 0x3CC3 (save) or 0x0C3C (reload), start that transfer. The start is taken at the clock edge that samples the sixth read, and xfer_store or xfer_recall is high for the one cycle after that edge.
- R3: A write cycle, or a read that does not match the next expected address, returns sequence progress to the start. Cycles with chip enable high leave progress unchanged. addr[14] is ignored for matching.
- R4: An accepted write marks the array dirty, and the end of any save or reload marks it clean. A save request of any kind while clean does nothing: busy stays low and no xfer_store pulse is issued.
- R5: A pwr_restore pulse in idle always starts a reload, whether the array is dirty or clean. It has priority over pwr_fail, the pin request and the software requests in the same cycle.
- R6: hsb_in sampled low while idle and dirty starts a save.
- R7: A pwr_fail pulse while idle and dirty enters a probe phase that drives the pin low. If hsb_in is seen low within PROBE_CYC cycles, a save starts. Otherwise the block releases the pin, returns to idle, and the array stays dirty. A pwr_fail pulse while clean does nothing.
- R8: busy is high for exactly STORE_CYC cycles for a save and RECALL_CYC cycles for a reload. When a probe is accepted at once, the probe adds one cycle.
- R9: While busy, arr_rd and arr_wr stay low, writes do not mark the array dirty, and reads do not advance the sequence. In idle, arr_wr is high in a write cycle and arr_rd is high in a read cycle with output enable low, in the same cycle.
- R10: hsb_drive is high exactly during the probe phase and during a save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| addr | input | 15 | Sampled bus address |
| hsb_in | input | 1 | Sampled level of the shared busy pin |
| pwr_fail | input | 1 | One-cycle power-fail event |
| pwr_restore | input | 1 | One-cycle power-restore event |
| busy | output | 1 | Transfer or probe in progress |
| hsb_drive | output | 1 | Pull the shared busy pin low |
| xfer_store | output | 1 | One-cycle save command to the array |
| xfer_recall | output | 1 | One-cycle reload command to the array |
| arr_rd | output | 1 | Read strobe to the volatile array |
| arr_wr | output | 1 | Write strobe to the volatile array |

## Verification
Each request is sampled at a rising edge. busy, hsb_drive and the one-cycle start command therefore change just after that same edge, and busy falls exactly STORE_CYC or RECALL_CYC edges later. The array strobes are combinational and follow the bus in the same cycle. The bench drives inputs on falling edges. A behavioural model steps on each rising edge, and all six outputs are compared one nanosecond after every rising edge, so each result is checked in the cycle it is due. Per-scenario tallies of start pulses and busy cycles then confirm the skipped, aborted, blocked and prioritised cases.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    localparam int ADDR_W  = 15;
    localparam int MATCH_W = 14;
    localparam int SEQ_LEN = 6;

    typedef logic [MATCH_W-1:0] match_addr_t;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_STORE  = 2'd1,
        XS_RECALL = 2'd2,
        XS_PROBE  = 2'd3
    } xfer_state_e;

    // one decoded bus cycle, already gated by busy
    typedef struct packed {
        logic        rd;
        logic        wr;
        match_addr_t addr;
    } bus_op_t;

    // transfer triggers presented to the sequencer
    typedef struct packed {
        logic restore;
        logic fail;
        logic hw_store;
        logic sw_recall;
        logic sw_store;
    } nv_req_t;

    // head of the unlock sequence; element 0 comes first
    localparam match_addr_t [SEQ_LEN-2:0] HEAD_DEF = {
        14'h0333, 14'h30F0, 14'h0F0F, 14'h15AA, 14'h2A55
    };
    localparam match_addr_t STORE_TAIL_DEF  = 14'h3CC3;
    localparam match_addr_t RECALL_TAIL_DEF = 14'h0C3C;

    function automatic bus_op_t decode_bus(
        input logic        ce_n,
        input logic        we_n,
        input logic        blocked,
        input match_addr_t a
    );
        bus_op_t op;
        op.rd   = !ce_n &&  we_n && !blocked;
        op.wr   = !ce_n && !we_n && !blocked;
        op.addr = a;
        return op;
    endfunction

endpackage

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
    import nvram_pkg::*;
#(
    parameter match_addr_t [SEQ_LEN-2:0] HEAD = HEAD_DEF,
    parameter match_addr_t STORE_TAIL  = STORE_TAIL_DEF,
    parameter match_addr_t RECALL_TAIL = RECALL_TAIL_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  bus_op_t op,
    output logic    sw_store,
    output logic    sw_recall
);

    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam int SLOTS  = 1 << STEP_W;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

    logic [STEP_W-1:0] step;
    logic [SLOTS-1:0]  head_hit;
    logic              at_tail;

    // one comparator per head slot; unused slots never match
    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        if (i < SEQ_LEN - 1) begin : g_live
            assign head_hit[i] = (op.addr == HEAD[i]);
        end else begin : g_pad
            assign head_hit[i] = 1'b0;
        end
    end

    assign at_tail   = (step == LAST);
    assign sw_store  = op.rd && at_tail && (op.addr == STORE_TAIL);
    assign sw_recall = op.rd && at_tail && (op.addr == RECALL_TAIL);

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            step <= '0;
        end else if (op.wr) begin
            step <= '0;
        end else if (op.rd) begin
            if (!at_tail && head_hit[step]) begin
                step <= step + 1'b1;
            end else begin
                step <= '0;
            end
        end
    end

    // R3
    write_clears_step_chk: assert property (@(posedge clk) disable iff (rst)
        op.wr |=> (step == '0));

    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        step <= LAST);

endmodule

// File: rtl/nv_xfer_fsm.sv
module nv_xfer_fsm
    import nvram_pkg::*;
#(
    parameter int STORE_CYC  = 24,
    parameter int RECALL_CYC = 10,
    parameter int PROBE_CYC  = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  nv_req_t req,
    input  logic    wr_done,
    output logic    busy,
    output logic    hsb_drive,
    output logic    store_go,
    output logic    recall_go
);

    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC)
                           ? ((STORE_CYC > PROBE_CYC) ? STORE_CYC : PROBE_CYC)
                           : ((RECALL_CYC > PROBE_CYC) ? RECALL_CYC : PROBE_CYC);
    localparam int TW = $clog2(MAX_CYC) + 1;
    localparam logic [TW-1:0] ST_LOAD = TW'(STORE_CYC - 1);
    localparam logic [TW-1:0] RC_LOAD = TW'(RECALL_CYC - 1);
    localparam logic [TW-1:0] PR_LOAD = TW'(PROBE_CYC - 1);

    xfer_state_e   state, nxt_state;
    logic [TW-1:0] timer, nxt_timer;
    logic          dirty;
    logic          go_st, go_rc;
    logic          finishing;

    assign finishing = (state == XS_STORE || state == XS_RECALL) && (timer == '0);

    always_comb begin
        nxt_state = state;
        nxt_timer = timer;
        go_st     = 1'b0;
        go_rc     = 1'b0;
        case (state)
            XS_IDLE: begin
                if (req.restore) begin
                    nxt_state = XS_RECALL;
                    nxt_timer = RC_LOAD;
                    go_rc     = 1'b1;
                end else if (req.fail) begin
                    if (dirty) begin
                        nxt_state = XS_PROBE;
                        nxt_timer = PR_LOAD;
                    end
                end else if (req.hw_store) begin
                    if (dirty) begin
                        nxt_state = XS_STORE;
                        nxt_timer = ST_LOAD;
                        go_st     = 1'b1;
                    end
                end else if (req.sw_recall) begin
                    nxt_state = XS_RECALL;
                    nxt_timer = RC_LOAD;
                    go_rc     = 1'b1;
                end else if (req.sw_store && dirty) begin
                    nxt_state = XS_STORE;
                    nxt_timer = ST_LOAD;
                    go_st     = 1'b1;
                end
            end
            XS_STORE, XS_RECALL: begin
                if (timer == '0) begin
                    nxt_state = XS_IDLE;
                end else begin
                    nxt_timer = timer - 1'b1;
                end
            end
            XS_PROBE: begin
                if (req.hw_store) begin
                    nxt_state = XS_STORE;
                    nxt_timer = ST_LOAD;
                    go_st     = 1'b1;
                end else if (timer == '0) begin
                    nxt_state = XS_IDLE;
                end else begin
                    nxt_timer = timer - 1'b1;
                end
            end
            default: nxt_state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= XS_IDLE;
            timer     <= '0;
            store_go  <= 1'b0;
            recall_go <= 1'b0;
        end else begin
            state     <= nxt_state;
            timer     <= nxt_timer;
            store_go  <= go_st;
            recall_go <= go_rc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
        end else if (finishing) begin
            dirty <= 1'b0;
        end else if (wr_done) begin
            dirty <= 1'b1;
        end
    end

    assign busy      = (state != XS_IDLE);
    assign hsb_drive = (state == XS_STORE) || (state == XS_PROBE);

    // R4
    store_needs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        store_go |-> dirty);

    // R4
    dirty_clear_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dirty) |-> $past(state == XS_STORE || state == XS_RECALL));

    // R8
    go_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (store_go || recall_go) |-> busy);

    // R5
    single_go_chk: assert property (@(posedge clk) disable iff (rst)
        !(store_go && recall_go));

endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int STORE_CYC  = 24,
    parameter int RECALL_CYC = 10,
    parameter int PROBE_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hsb_in,
    input  logic              pwr_fail,
    input  logic              pwr_restore,
    output logic              busy,
    output logic              hsb_drive,
    output logic              xfer_store,
    output logic              xfer_recall,
    output logic              arr_rd,
    output logic              arr_wr
);

    bus_op_t op;
    nv_req_t req;
    logic    sw_store, sw_recall;
    logic    unused_top_bit;

    assign unused_top_bit = addr[ADDR_W-1];
    assign op = decode_bus(ce_n, we_n, busy, addr[MATCH_W-1:0]);

    assign arr_rd = op.rd && !oe_n;
    assign arr_wr = op.wr;

    nv_seq_detect u_seq (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .op        (op),
        .sw_store  (sw_store),
        .sw_recall (sw_recall)
    );

    assign req.restore   = pwr_restore;
    assign req.fail      = pwr_fail;
    assign req.hw_store  = !hsb_in;
    assign req.sw_recall = sw_recall;
    assign req.sw_store  = sw_store;

    nv_xfer_fsm #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .PROBE_CYC  (PROBE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr_done   (op.wr),
        .busy      (busy),
        .hsb_drive (hsb_drive),
        .store_go  (xfer_store),
        .recall_go (xfer_recall)
    );

    // R9
    no_strobe_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_store |-> (!arr_wr && !arr_rd));

endmodule

// File: tb/nvram_ctrl_test.sv
module nvram_ctrl_test;

    localparam int ST = 24;
    localparam int RC = 10;
    localparam int PR = 6;
    localparam logic [13:0] SAVE_A = 14'h3CC3;
    localparam logic [13:0] LOAD_A = 14'h0C3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic        pwr_fail = 1'b0, pwr_restore = 1'b0;
    logic        ext_hsb = 1'b1, pin_stuck = 1'b0;
    logic        hsb_in;
    logic        busy, hsb_drive, xfer_store, xfer_recall, arr_rd, arr_wr;

    logic [13:0] head [5] = '{14'h2A55, 14'h15AA, 14'h0F0F, 14'h30F0, 14'h0333};

    int n_chk = 0, n_err = 0;
    int n_sgo = 0, n_rgo = 0, n_busy = 0;
    int s_sgo, s_rgo, s_busy;

    // model state: 0 idle, 1 save, 2 reload, 3 probe
    int m_state = 0, m_timer = 0, m_seq = 0;
    bit m_dirty = 0, m_sgo = 0, m_rgo = 0;

    assign hsb_in = hsb_drive ? pin_stuck : ext_hsb;

    always #2 clk = ~clk;

    nvram_ctrl uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .hsb_in(hsb_in), .pwr_fail(pwr_fail),
        .pwr_restore(pwr_restore), .busy(busy), .hsb_drive(hsb_drive),
        .xfer_store(xfer_store), .xfer_recall(xfer_recall),
        .arr_rd(arr_rd), .arr_wr(arr_wr)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_timer = 0; m_seq = 0; m_dirty = 0; m_sgo = 0; m_rgo = 0;
        end else begin
            bit was_busy, rd, wr, pin, s_sw, r_sw, fin;
            was_busy = (m_state != 0);
            rd  = !ce_n &&  we_n && !was_busy;
            wr  = !ce_n && !we_n && !was_busy;
            pin = (m_state == 1 || m_state == 3) ? pin_stuck : ext_hsb;
            s_sw = rd && m_seq == 5 && addr[13:0] == SAVE_A;
            r_sw = rd && m_seq == 5 && addr[13:0] == LOAD_A;
            m_sgo = 0; m_rgo = 0; fin = 0;
            if (m_state == 0) begin
                if (pwr_restore) begin m_state = 2; m_timer = RC - 1; m_rgo = 1; end
                else if (pwr_fail) begin
                    if (m_dirty) begin m_state = 3; m_timer = PR - 1; end
                end else if (!pin) begin
                    if (m_dirty) begin m_state = 1; m_timer = ST - 1; m_sgo = 1; end
                end else if (r_sw) begin m_state = 2; m_timer = RC - 1; m_rgo = 1; end
                else if (s_sw && m_dirty) begin m_state = 1; m_timer = ST - 1; m_sgo = 1; end
            end else if (m_state == 3) begin
                if (!pin) begin m_state = 1; m_timer = ST - 1; m_sgo = 1; end
                else if (m_timer == 0) m_state = 0;
                else m_timer--;
            end else begin
                if (m_timer == 0) begin m_state = 0; fin = 1; end
                else m_timer--;
            end
            if (fin) m_dirty = 0;
            else if (wr) m_dirty = 1;
            if (was_busy || wr) m_seq = 0;
            else if (rd) m_seq = (m_seq < 5 && addr[13:0] == head[m_seq]) ? m_seq + 1 : 0;
        end
    end

    // per-cycle comparison just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            bit mb;
            mb = (m_state != 0);
            chk("R8",  "busy", busy, mb);
            chk("R10", "hsb_drive", hsb_drive, (m_state == 1 || m_state == 3));
            chk("R2",  "xfer_store", xfer_store, m_sgo);
            chk("R5",  "xfer_recall", xfer_recall, m_rgo);
            chk("R9",  "arr_wr", arr_wr, !mb && !ce_n && !we_n);
            chk("R9",  "arr_rd", arr_rd, !mb && !ce_n && we_n && !oe_n);
            n_sgo += xfer_store;
            n_rgo += xfer_recall;
            n_busy += busy;
        end
    end

    task automatic bus(input logic c, input logic w, input logic o, input logic [14:0] a);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b1, 1'b1, 1'b1, 15'h0);
    endtask

    task automatic rd(input logic [14:0] a); bus(1'b0, 1'b1, 1'b0, a); endtask
    task automatic wr(input logic [14:0] a); bus(1'b0, 1'b0, 1'b1, a); endtask

    task automatic seq(input logic [13:0] tail, input logic top);
        for (int i = 0; i < 5; i++) rd({top, head[i]});
        rd({top, tail});
    endtask

    task automatic mark;
        s_sgo = n_sgo; s_rgo = n_rgo; s_busy = n_busy;
    endtask

    task automatic verify(string tag, int es, int er, int eb);
        idle(45);
        chk(tag, "save pulses", n_sgo - s_sgo, es);
        chk(tag, "reload pulses", n_rgo - s_rgo, er);
        chk(tag, "busy cycles", n_busy - s_busy, eb);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "hsb_drive after reset", hsb_drive, 0);
        chk("R1", "xfer after reset", xfer_store | xfer_recall, 0);

        // R1 R4: clean after reset, save skipped
        mark(); seq(SAVE_A, 1'b0); verify("R4", 0, 0, 0);

        // R2 R8: dirty then software save
        mark(); wr(15'h0010); seq(SAVE_A, 1'b0); verify("R2", 1, 0, ST);

        // R4: clean again after save
        mark(); seq(SAVE_A, 1'b0); verify("R4", 0, 0, 0);

        // R3: top address bit ignored
        mark(); wr(15'h4001); seq(SAVE_A, 1'b1); verify("R3", 1, 0, ST);

        // R2 R8: software reload while clean
        mark(); seq(LOAD_A, 1'b0); verify("R2", 0, 1, RC);

        // R3: wrong address breaks the sequence
        mark(); wr(15'h0002);
        rd({1'b0, head[0]}); rd({1'b0, head[1]}); rd(15'h1111);
        rd({1'b0, head[3]}); rd({1'b0, head[4]}); rd({1'b0, SAVE_A});
        verify("R3", 0, 0, 0);

        // R3: a write inside the sequence breaks it
        mark();
        rd({1'b0, head[0]}); rd({1'b0, head[1]}); rd({1'b0, head[2]});
        wr(15'h0003);
        rd({1'b0, head[3]}); rd({1'b0, head[4]}); rd({1'b0, SAVE_A});
        verify("R3", 0, 0, 0);

        // R3: idle gaps keep progress
        mark();
        for (int i = 0; i < 5; i++) begin rd({1'b0, head[i]}); idle(2); end
        rd({1'b0, SAVE_A});
        verify("R3", 1, 0, ST);

        // R6: pin request while clean, then while dirty
        mark(); @(negedge clk); ext_hsb = 1'b0; @(negedge clk); ext_hsb = 1'b1;
        verify("R6", 0, 0, 0);
        mark(); wr(15'h0020); idle(1);
        @(negedge clk); ext_hsb = 1'b0; @(negedge clk); ext_hsb = 1'b1;
        verify("R6", 1, 0, ST);

        // R7: power fail, pin follows the drive
        mark(); wr(15'h0030); idle(1);
        @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
        verify("R7", 1, 0, ST + 1);

        // R7: pin held high, probe aborts and dirty is kept
        pin_stuck = 1'b1;
        mark(); wr(15'h0031); idle(1);
        @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
        verify("R7", 0, 0, PR);
        pin_stuck = 1'b0;
        mark(); seq(SAVE_A, 1'b0); verify("R7", 1, 0, ST);

        // R7: power fail while clean
        mark(); @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
        verify("R7", 0, 0, 0);

        // R5: restore while clean, then restore beats fail
        mark(); @(negedge clk); pwr_restore = 1'b1; @(negedge clk); pwr_restore = 1'b0;
        verify("R5", 0, 1, RC);
        mark(); wr(15'h0040); idle(1);
        @(negedge clk); pwr_restore = 1'b1; pwr_fail = 1'b1;
        @(negedge clk); pwr_restore = 1'b0; pwr_fail = 1'b0;
        verify("R5", 0, 1, RC);

        // R9: accesses during a save are blocked
        mark(); wr(15'h0050); seq(SAVE_A, 1'b0);
        wr(15'h0051); seq(LOAD_A, 1'b0);
        verify("R9", 1, 0, ST);
        mark(); seq(SAVE_A, 1'b0); verify("R9", 0, 0, 0);

        summary();
    end

endmodule